// File: doc/BRIEF.md
# Register File with Deferred-Error Tags

This block is a general-purpose register file in which every entry carries a one-bit "suspect" tag beside its data. An instruction whose result may be corrupt, for example one read from a parity-failing queue slot, still writes its destination register. Instead of trapping at once, the write stores the tag with the data. The fault is reported only if a later instruction actually reads that register. A result that is overwritten before anyone reads it is dead, so it never raises a false alarm.

The block has one write port, which carries address, data and tag, and two read ports, which carry address and an enable. All ports are accepted on every clock. There is no back-pressure: `wr_valid`, `rd0_en` and `rd1_en` are qualifiers, and the block is always ready. Read data and the error report appear one cycle after the read is presented. The error report is a single-cycle pulse with the index of the offending register and a flag for the case where both reads were faulty. Register 0 is hard-wired to zero and is never tagged.

Top module: `poison_regfile`

## Requirements
- R1: A write with `wr_valid`=1 and `wr_poison`=1 to register k≠0 stores the data and sets k's tag, and produces no error pulse in the following cycle.
- R2: A read with its enable high to a tagged register k produces `err_valid`=1 with `err_idx`=k exactly one cycle later.
- R3: A write with `wr_poison`=0 clears the tag of its destination, so a tagged register that is overwritten cleanly before any read never produces an error.
- R4: A read port whose enable is low raises no error whatever its address, and its `rdN_data` output keeps its previous value.
- R5: Register 0 always reads as zero and never raises an error. Writes to it are discarded.
- R6: When a register is written and read in the same cycle, the read returns the data and tag held before that write.
- R7: If both ports read tagged registers in one cycle, `err_idx` reports the port 0 address and `err_multi`=1 in the next cycle. Otherwise `err_multi`=0.
- R8: Reset (`rst_n`=0, asynchronous) clears every data word and every tag, and drives `rd0_data`, `rd1_data`, `err_valid`, `err_idx` and `err_multi` to zero.
- R9: `err_valid` is high for one cycle per cycle containing a faulting read. Repeated faulting reads in back-to-back cycles give back-to-back pulses, and the tag stays set after the read.
- R10: An enabled read returns the register contents on `rdN_data` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write qualifier |
| wr_addr | input | AW | Destination register |
| wr_data | input | DATA_W | Write data |
| wr_poison | input | 1 | Result is suspect; store tag |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_addr | input | AW | Read port 0 address |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_addr | input | AW | Read port 1 address |
| rd0_data | output | DATA_W | Read port 0 data (one-cycle latency) |
| rd1_data | output | DATA_W | Read port 1 data (one-cycle latency) |
| err_valid | output | 1 | One-cycle fault pulse |
| err_idx | output | AW | Register that caused the fault |
| err_multi | output | 1 | Both ports hit tagged registers |

## Verification
Two behaviours can fall in the same cycle: a write that sets or clears a tag, and a read of the same register. Two reads that both hit tagged registers can also coincide. The bench provokes both in directed steps: a tagged write alongside a read of the same index, a clean overwrite alongside a read, and paired reads of two tagged registers. A long random phase over a small address range then makes these collisions frequent. A behavioural model applies each cycle's reads before its write, and every output is compared against it one clock later.

// File: rtl/poison_rf_pkg.sv
package poison_rf_pkg;
  typedef enum logic {PORT0 = 1'b0, PORT1 = 1'b1} rd_port_e;
  localparam int unsigned NUM_RD_PORTS = 2;
endpackage

// File: rtl/prf_storage.sv
module prf_storage #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned AW       = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_valid,
  input  logic [AW-1:0]                    wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             wr_poison,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  words,
  output logic [NUM_REGS-1:0]              tags
);
  logic wr_live;
  assign wr_live = wr_valid && (wr_addr != '0) && (32'(wr_addr) < NUM_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words <= '0;
      tags  <= '0;
    end else if (wr_live) begin
      words[wr_addr] <= wr_data;
      tags[wr_addr]  <= wr_poison;
    end
  end
endmodule

// File: rtl/prf_read_port.sv
module prf_read_port #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned AW       = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en,
  input  logic [AW-1:0]                    addr,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  words,
  input  logic [NUM_REGS-1:0]              tags,
  output logic                             hit,
  output logic [DATA_W-1:0]                data_q
);
  logic live;
  assign live = (addr != '0) && (32'(addr) < NUM_REGS);
  assign hit  = en && live && tags[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  data_q <= '0;
    else if (en) data_q <= live ? words[addr] : '0;
  end
endmodule

// File: rtl/prf_err_report.sv
module prf_err_report
  import poison_rf_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_RD_PORTS-1:0]           hit,
  input  logic [NUM_RD_PORTS-1:0][AW-1:0]   addr,
  output logic                              err_valid,
  output logic [AW-1:0]                     err_idx,
  output logic                              err_multi
);
  rd_port_e winner;
  assign winner = hit[PORT0] ? PORT0 : PORT1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_idx   <= '0;
      err_multi <= 1'b0;
    end else begin
      err_valid <= |hit;
      err_multi <= &hit;
      if (|hit) err_idx <= addr[winner];
    end
  end
endmodule

// File: rtl/poison_regfile.sv
module poison_regfile
  import poison_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned AW       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_poison,
  input  logic              rd0_en,
  input  logic [AW-1:0]     rd0_addr,
  input  logic              rd1_en,
  input  logic [AW-1:0]     rd1_addr,
  output logic [DATA_W-1:0] rd0_data,
  output logic [DATA_W-1:0] rd1_data,
  output logic              err_valid,
  output logic [AW-1:0]     err_idx,
  output logic              err_multi
);
  logic [NUM_REGS-1:0][DATA_W-1:0]      words;
  logic [NUM_REGS-1:0]                  tags;
  logic [NUM_RD_PORTS-1:0]              en_v, hit_v;
  logic [NUM_RD_PORTS-1:0][AW-1:0]      addr_v;
  logic [NUM_RD_PORTS-1:0][DATA_W-1:0]  data_v;

  assign en_v   = {rd1_en, rd0_en};
  assign addr_v = {rd1_addr, rd0_addr};

  prf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_poison(wr_poison), .words(words), .tags(tags));

  for (genvar p = 0; p < NUM_RD_PORTS; p++) begin : g_rd
    prf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .AW(AW)) u_port (
      .clk(clk), .rst_n(rst_n), .en(en_v[p]), .addr(addr_v[p]),
      .words(words), .tags(tags), .hit(hit_v[p]), .data_q(data_v[p]));
  end

  assign rd0_data = data_v[PORT0];
  assign rd1_data = data_v[PORT1];

  prf_err_report #(.AW(AW)) u_err (
    .clk(clk), .rst_n(rst_n), .hit(hit_v), .addr(addr_v),
    .err_valid(err_valid), .err_idx(err_idx), .err_multi(err_multi));
endmodule

// File: rtl/poison_regfile_chk.sv
module poison_regfile_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned AW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [AW-1:0]     wr_addr,
  input logic              wr_poison,
  input logic              rd0_en,
  input logic [AW-1:0]     rd0_addr,
  input logic              rd1_en,
  input logic [DATA_W-1:0] rd0_data,
  input logic              err_valid,
  input logic [AW-1:0]     err_idx,
  input logic              err_multi
);
  // R1
  poison_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_poison && !rd0_en && !rd1_en) |=> !err_valid);

  // R2
  tagged_read_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_poison && wr_addr != '0) ##1 (rd0_en && rd0_addr == $past(wr_addr))
      |=> (err_valid && err_idx == $past(rd0_addr)));

  // R3
  clean_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_poison) ##1 (rd0_en && rd0_addr == $past(wr_addr) && !rd1_en)
      |=> !err_valid);

  // R4
  idle_no_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd0_en && !rd1_en) |=> !err_valid);

  // R5
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_en && rd0_addr == '0) |=> (rd0_data == '0));

  // R7
  multi_implies_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_multi |-> err_valid);

  // R5
  err_never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_idx != '0));
endmodule

bind poison_regfile poison_regfile_chk #(.DATA_W(DATA_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_poison(wr_poison), .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd1_en(rd1_en),
  .rd0_data(rd0_data), .err_valid(err_valid), .err_idx(err_idx), .err_multi(err_multi));

// File: tb/tb_poison_regfile.sv
`timescale 1ns/1ps
module tb_poison_regfile;
  localparam int N = 16, DW = 32, AW = 4;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_poison = 0, rd0_en = 0, rd1_en = 0;
  logic [AW-1:0] wr_addr = 0, rd0_addr = 0, rd1_addr = 0;
  logic [DW-1:0] wr_data = 0;
  logic [DW-1:0] rd0_data, rd1_data;
  logic err_valid, err_multi;
  logic [AW-1:0] err_idx;

  always #2.5 clk = ~clk;

  poison_regfile #(.NUM_REGS(N), .DATA_W(DW)) dut (.*);

  int compared = 0, mismatched = 0, cycles = 0;
  logic [DW-1:0] m_mem [N];
  bit            m_tag [N];
  logic [DW-1:0] e_rd0 = 0, e_rd1 = 0;
  bit e_err = 0, e_multi = 0;
  logic [AW-1:0] e_idx = 0;
  string e_req = "R8";

  task automatic cmp(string req, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    cmp((e_req == "R2" || e_req == "R7") ? "R10" : e_req, "rd0_data", rd0_data, e_rd0);
    cmp(e_req, "rd1_data", rd1_data, e_rd1);
    cmp(e_req, "err_valid", err_valid, e_err);
    cmp((e_req == "R9") ? "R9" : "R7", "err_multi", err_multi, e_multi);
    if (e_err) cmp(e_req, "err_idx", err_idx, e_idx);
  endtask

  task automatic step(bit wv, int wa, logic [DW-1:0] wd, bit wp,
                      bit r0e, int r0a, bit r1e, int r1a, string req);
    bit h0, h1;
    @(negedge clk);
    check_outputs();
    wr_valid = wv; wr_addr = AW'(wa); wr_data = wd; wr_poison = wp;
    rd0_en = r0e; rd0_addr = AW'(r0a); rd1_en = r1e; rd1_addr = AW'(r1a);
    // model: reads see state before this cycle's write
    h0 = r0e && r0a != 0 && m_tag[r0a];
    h1 = r1e && r1a != 0 && m_tag[r1a];
    if (r0e) e_rd0 = (r0a == 0) ? '0 : m_mem[r0a];
    if (r1e) e_rd1 = (r1a == 0) ? '0 : m_mem[r1a];
    e_err = h0 || h1;
    e_multi = h0 && h1;
    if (h0) e_idx = AW'(r0a); else if (h1) e_idx = AW'(r1a);
    e_req = req;
    if (wv && wa != 0) begin m_mem[wa] = wd; m_tag[wa] = wp; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    wr_valid = 0; rd0_en = 0; rd1_en = 0;
    for (int i = 0; i < N; i++) begin m_mem[i] = '0; m_tag[i] = 0; end
    e_rd0 = 0; e_rd1 = 0; e_err = 0; e_multi = 0; e_idx = 0; e_req = "R8";
    @(negedge clk);
    cmp("R8", "rd0_data", rd0_data, 0);
    cmp("R8", "err_valid", err_valid, 0);
    cmp("R8", "err_idx", err_idx, 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: tagged write, no error at write time
    step(1, 3, 32'hAAAA0003, 1, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2 / R10: read tagged reg
    step(0, 0, 0, 0, 1, 3, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    // R9: back-to-back faulting reads, tag persists
    step(0, 0, 0, 0, 1, 3, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 1, 3, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R3: tagged then clean overwrite, then read
    step(1, 5, 32'h55, 1, 0, 0, 0, 0, "R3");
    step(1, 5, 32'h56, 0, 0, 0, 0, 0, "R3");
    step(0, 0, 0, 0, 1, 5, 1, 5, "R3");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R4: disabled read of tagged reg
    step(1, 6, 32'h66, 1, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 6, 0, 6, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R4");
    // R5: register 0
    step(1, 0, 32'hDEAD, 1, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 1, 0, 1, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R6: same-cycle write and read
    step(1, 7, 32'h77, 0, 0, 0, 0, 0, "R6");
    step(1, 7, 32'h78, 1, 1, 7, 0, 0, "R6");
    step(1, 7, 32'h79, 0, 1, 7, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R6");
    // R7: both ports hit tagged registers
    step(1, 9, 32'h99, 1, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 1, 6, 1, 9, "R7");
    step(0, 0, 0, 0, 1, 3, 1, 9, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 9, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R7");
    // R8: reset clears tags
    step(1, 10, 32'hA0, 1, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8");
    do_reset();
    step(0, 0, 0, 0, 1, 10, 1, 3, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8");
    // random collisions over a small range
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 1), $urandom_range(0, 5), $urandom, $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 5),
           $urandom_range(0, 1), $urandom_range(0, 5), "R2");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule